// File: doc/BRIEF.md
# Write-Once Node Identifier Register

This block stores a 64-bit node identifier that a serial-bus link controller publishes as the third and fourth quadlets of its bus information block. The identifier has three fields. The vendor field is 24 bits and the upper chip field is 8 bits; together they form the high word. The lower chip field is 32 bits and forms the low word. Each field can be filled once after a hardware reset. The value comes either from an autonomous loader port, which a local non-volatile store feeds, or from one host register write. After that the field is locked until the next hardware reset.

The block has no software-reset input, so a chip-level soft reset never disturbs the identifier. It produces an identifier-valid flag. It also gates the link-enable request: the link turns on only while every field has been loaded and the identifier is non-zero. A request made too early is held off and is not remembered.

Top module: `node_id_reg`

## Requirements
- R1: While `hw_rst` is high at a clock edge, all fields, their load flags, `rd_data`, `id_valid` and `link_en` are cleared to zero.
- R2: Register reads return data one cycle after `rd_addr` is presented. Offset 0x24 returns the high word `{vendor[23:0], chip_hi[7:0]}`. Offset 0x28 returns the low word `chip_lo[31:0]`. Any other offset returns zero.
- R3: A host write to offset 0x24 loads vendor from `host_wdata[31:8]` and chip_hi from `host_wdata[7:0]`. A host write to offset 0x28 loads chip_lo from `host_wdata[31:0]`. The new value shows on `id_hi`/`id_lo` after that clock edge.
- R4: When `ld_valid` is high, the loader port fills one field chosen by `ld_sel`. The value 0 selects vendor (`ld_data[23:0]`), 1 selects chip_hi (`ld_data[7:0]`) and 2 selects chip_lo (`ld_data[31:0]`). The value 3 selects no field.
- R5: Each field accepts exactly one load after hardware reset. Every later host write or loader transfer to that field is dropped, and the field reads back unchanged.
- R6: If the loader and a host write target the same field in the same cycle, the loader value is stored. A field of that host write that the loader does not target is still loaded from the host data.
- R7: `id_valid` and `link_en` are registered. They respond one clock edge after the field change or request change that causes them.
- R8: `id_valid` is high only when all three fields have been loaded and the 64-bit identifier is non-zero. An identifier loaded as all zeros stays invalid.
- R9: `link_en` equals `link_en_req` ANDed with the validity condition. An early request is held off, not latched, and dropping the request drops `link_en`.
- R10: `id_hi` and `id_lo` continuously present the high and low words for the bus information block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous active-high hardware (power) reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host write offset |
| host_wdata | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read offset |
| rd_data | output | 32 | Registered read data |
| ld_valid | input | 1 | Loader transfer strobe |
| ld_sel | input | 2 | Loader target field |
| ld_data | input | 32 | Loader data, right-aligned |
| link_en_req | input | 1 | Requested link enable |
| id_hi | output | 32 | High identifier word (third quadlet) |
| id_lo | output | 32 | Low identifier word (fourth quadlet) |
| id_valid | output | 1 | Identifier loaded and non-zero |
| link_en | output | 1 | Gated link enable |

## Verification
A load flag stuck low would let a second write change `id_hi` or `id_lo` on the edge right after that write. A flag stuck high would freeze the field at zero. Both show at the ports one cycle later. A wrong collision priority shows as host data in a field on the edge that follows the shared cycle. A faulty validity term shows as `link_en` rising one edge after a request while a field is still empty, or while the identifier is still all zeros.

// File: rtl/node_id_pkg.sv
package node_id_pkg;
  localparam int VEND_W  = 24;
  localparam int CHIPH_W = 8;
  localparam int CHIPL_W = 32;
  localparam int NFLD    = 3;
  localparam int REG_W   = 32;
  localparam int ID_W    = VEND_W + CHIPH_W + CHIPL_W;

  // field width by index: 0 vendor, 1 chip high, 2 chip low
  function automatic int fld_w(input int i);
    case (i)
      0:       return VEND_W;
      1:       return CHIPH_W;
      default: return CHIPL_W;
    endcase
  endfunction

  // field lsb inside the 64-bit identifier
  function automatic int fld_lsb(input int i);
    case (i)
      0:       return CHIPH_W + CHIPL_W;
      1:       return CHIPL_W;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/wo_field.sv
module wo_field #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic         host_en,
  input  logic [W-1:0] host_val,
  output logic [W-1:0] val,
  output logic         done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      val  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      if (ld_en) begin
        val  <= ld_val;
        done <= 1'b1;
      end else if (host_en) begin
        val  <= host_val;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/id_gate.sv
module id_gate #(
  parameter int NF   = 3,
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NF-1:0]   done,
  input  logic [ID_W-1:0] id,
  input  logic            link_req,
  output logic            id_valid,
  output logic            link_en
);
  logic ok;
  assign ok = (&done) && (|id);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_valid <= 1'b0;
      link_en  <= 1'b0;
    end else begin
      id_valid <= ok;
      link_en  <= link_req && ok;
    end
  end
endmodule

// File: rtl/node_id_reg.sv
module node_id_reg
  import node_id_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] HI_OFS = 8'h24,
  parameter logic [ADDR_W-1:0] LO_OFS = 8'h28
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [REG_W-1:0]  host_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              ld_valid,
  input  logic [1:0]        ld_sel,
  input  logic [REG_W-1:0]  ld_data,
  input  logic              link_en_req,
  output logic [REG_W-1:0]  id_hi,
  output logic [REG_W-1:0]  id_lo,
  output logic              id_valid,
  output logic              link_en
);
  logic [ID_W-1:0] id;
  logic [NFLD-1:0] done;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int W    = fld_w(g);
    localparam int LSB  = fld_lsb(g);
    localparam int DLSB = LSB % REG_W;
    localparam logic [ADDR_W-1:0] OFS = (LSB >= REG_W) ? HI_OFS : LO_OFS;

    wo_field #(.W(W)) u_fld (
      .clk      (clk),
      .rst      (hw_rst),
      .ld_en    (ld_valid && (ld_sel == 2'(g))),
      .ld_val   (ld_data[W-1:0]),
      .host_en  (host_wr && (host_addr == OFS)),
      .host_val (host_wdata[DLSB +: W]),
      .val      (id[LSB +: W]),
      .done     (done[g])
    );
  end

  assign id_hi = id[ID_W-1:REG_W];
  assign id_lo = id[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (hw_rst)                rd_data <= '0;
    else if (rd_addr == HI_OFS) rd_data <= id_hi;
    else if (rd_addr == LO_OFS) rd_data <= id_lo;
    else                        rd_data <= '0;
  end

  id_gate #(.NF(NFLD), .ID_W(ID_W)) u_gate (
    .clk      (clk),
    .rst      (hw_rst),
    .done     (done),
    .id       (id),
    .link_req (link_en_req),
    .id_valid (id_valid),
    .link_en  (link_en)
  );
endmodule

// File: rtl/node_id_chk.sv
module node_id_chk #(
  parameter int NF = 3
) (
  input logic          clk,
  input logic          hw_rst,
  input logic [NF-1:0] done,
  input logic [31:0]   id_hi,
  input logic [31:0]   id_lo,
  input logic          id_valid,
  input logic          link_en,
  input logic          link_en_req
);
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (hw_rst)
    $past(hw_rst) |-> (id_hi == '0 && id_lo == '0 && !id_valid && !link_en));

  a_r5_flags_sticky: assert property (@(posedge clk) disable iff (hw_rst)
    ((done & $past(done)) == $past(done)));

  a_r5_locked_words: assert property (@(posedge clk) disable iff (hw_rst)
    id_valid |=> ($stable(id_hi) && $stable(id_lo)));

  a_r8_valid_loaded_nonzero: assert property (@(posedge clk) disable iff (hw_rst)
    id_valid |-> ((&done) && ((id_hi | id_lo) != '0)));

  a_r9_link_needs_valid: assert property (@(posedge clk) disable iff (hw_rst)
    link_en |-> id_valid);

  a_r9_link_needs_req: assert property (@(posedge clk) disable iff (hw_rst)
    link_en |-> $past(link_en_req));
endmodule

bind node_id_reg node_id_chk #(.NF(node_id_pkg::NFLD)) u_chk (
  .clk         (clk),
  .hw_rst      (hw_rst),
  .done        (done),
  .id_hi       (id_hi),
  .id_lo       (id_lo),
  .id_valid    (id_valid),
  .link_en     (link_en),
  .link_en_req (link_en_req)
);

// File: tb/node_id_reg_tb.sv
module node_id_reg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        hw_rst = 1'b1;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ld_valid = 1'b0;
  logic [1:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic        link_en_req = 1'b0;
  logic [31:0] id_hi, id_lo;
  logic        id_valid, link_en;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  node_id_reg u_dut (
    .clk(clk), .hw_rst(hw_rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_data(ld_data),
    .link_en_req(link_en_req), .id_hi(id_hi), .id_lo(id_lo),
    .id_valid(id_valid), .link_en(link_en)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_reset();
    hw_rst = 1'b1; tick(); tick(); hw_rst = 1'b0;
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d; tick(); host_wr = 1'b0;
  endtask

  task automatic lwrite(input logic [1:0] s, input logic [31:0] d);
    ld_valid = 1'b1; ld_sel = s; ld_data = d; tick(); ld_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    rd_addr = a; tick(); v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    link_en_req = 1'b1;
    do_reset();
    check("R1 id_hi", id_hi, 32'h0);
    check("R1 id_lo", id_lo, 32'h0);
    check("R1 id_valid", {31'b0, id_valid}, 32'h0);
    check("R1 link_en", {31'b0, link_en}, 32'h0);
    rd(8'h24, v);
    check("R1 rd_data", v, 32'h0);
  endtask

  task automatic t_host_hi();
    logic [31:0] v;
    hwrite(8'h24, 32'hA1B2C3D4);
    check("R3 id_hi host", id_hi, 32'hA1B2C3D4);
    check("R10 id_lo untouched", id_lo, 32'h0);
    rd(8'h24, v);
    check("R2 read 0x24", v, 32'hA1B2C3D4);
    check("R9 early request held off", {31'b0, link_en}, 32'h0);
    check("R8 partial load invalid", {31'b0, id_valid}, 32'h0);
  endtask

  task automatic t_write_once_hi();
    hwrite(8'h24, 32'h11111111);
    check("R5 second host write", id_hi, 32'hA1B2C3D4);
    lwrite(2'd0, 32'h00FFFFFF);
    check("R5 late loader vendor", id_hi, 32'hA1B2C3D4);
  endtask

  task automatic t_collision_lo();
    logic [31:0] v;
    ld_valid = 1'b1; ld_sel = 2'd2; ld_data = 32'h13572468;
    host_wr = 1'b1; host_addr = 8'h28; host_wdata = 32'hDEADBEEF;
    tick();
    ld_valid = 1'b0; host_wr = 1'b0;
    check("R6 loader wins lo", id_lo, 32'h13572468);
    check("R7 valid one edge late", {31'b0, id_valid}, 32'h0);
    tick();
    check("R8 valid after full load", {31'b0, id_valid}, 32'h1);
    check("R9 link_en follows request", {31'b0, link_en}, 32'h1);
    rd(8'h28, v);
    check("R2 read 0x28", v, 32'h13572468);
    rd(8'h30, v);
    check("R2 unmapped offset", v, 32'h0);
    link_en_req = 1'b0;
    tick();
    check("R9 drop request", {31'b0, link_en}, 32'h0);
    check("R8 valid stays", {31'b0, id_valid}, 32'h1);
    hwrite(8'h28, 32'h0);
    check("R5 lo locked", id_lo, 32'h13572468);
  endtask

  task automatic t_mixed_hi();
    do_reset();
    check("R1 second reset clears hi", id_hi, 32'h0);
    ld_valid = 1'b1; ld_sel = 2'd0; ld_data = 32'h00ABCDEF;
    host_wr = 1'b1; host_addr = 8'h24; host_wdata = 32'h12345678;
    tick();
    ld_valid = 1'b0; host_wr = 1'b0;
    check("R6 vendor from loader, chip_hi from host", id_hi, 32'hABCDEF78);
    lwrite(2'd1, 32'h00000099);
    check("R5 chip_hi locked", id_hi, 32'hABCDEF78);
    lwrite(2'd3, 32'hFFFFFFFF);
    check("R4 sel 3 no field", id_lo, 32'h0);
    lwrite(2'd2, 32'hCAFEF00D);
    check("R4 loader lo", id_lo, 32'hCAFEF00D);
  endtask

  task automatic t_zero_id();
    do_reset();
    link_en_req = 1'b1;
    lwrite(2'd0, 32'h0);
    lwrite(2'd1, 32'h0);
    lwrite(2'd2, 32'h0);
    tick();
    check("R8 zero id invalid", {31'b0, id_valid}, 32'h0);
    check("R9 zero id blocks link", {31'b0, link_en}, 32'h0);
    hwrite(8'h24, 32'h55AA55AA);
    check("R5 zero-loaded hi locked", id_hi, 32'h0);
    tick();
    check("R9 still blocked", {31'b0, link_en}, 32'h0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_host_hi();
    t_write_once_hi();
    t_collision_lo();
    t_mixed_hi();
    t_zero_id();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule